// File: doc/BRIEF.md
# Packed Floating-Point Compare and Min/Max Unit

This block takes two 128-bit operands that hold IEEE-754 values packed side by side. It returns one 128-bit result, built lane by lane. A width select treats the operands either as four 32-bit single-precision lanes or as two 64-bit double-precision lanes. In each lane the block returns either a compare mask or the smaller or larger of the two inputs. The block does its own NaN detection and its own ordered comparison of sign-magnitude values. It does no arithmetic and raises no exception flags.

Min and max are deliberately asymmetric. When the inputs are tied or unordered, the second operand wins. A compare writes a whole lane of ones when the chosen predicate holds and a whole lane of zeros when it does not. A scalar select limits the work to the lowest lane. The bits above that lane are copied from the first operand, which plays the role of the destination register. By default the result is registered, so it appears one clock after the inputs.

Top module: `vec_fcmp_minmax`

## Requirements
- R1: `wide_lane`=0 splits the operands into four 32-bit lanes at bits [32k+31:32k]. `wide_lane`=1 splits them into two 64-bit lanes at bits [64k+63:64k]. Each lane is computed independently of the others.
- R2: `func_sel` encoding: 0 = compare, 1 = minimum, 2 = maximum. Code 3 behaves exactly like compare.
- R3: Minimum with no NaN input returns `src_a` when `src_a` < `src_b`. In every other case it returns `src_b`.
- R4: Maximum with no NaN input returns `src_a` only when `src_b` < `src_a`. Equal inputs therefore return `src_b`.
- R5: For minimum and maximum, if either lane input is a NaN, the result is `src_b`'s lane. This covers a signalling NaN in `src_b` and any quiet or signalling NaN in `src_a`. A NaN has an all-ones exponent and a nonzero fraction. It is signalling when the top fraction bit is clear.
- R6: `pred_sel` encoding: 0 eq, 1 lt, 2 le, 3 unordered, 4 neq, 5 not-lt, 6 not-le, 7 ordered. When any lane input is NaN, eq, lt and le give false, and neq, not-lt and not-le give true. Unordered is true exactly when a NaN is present. Ordered is true exactly when no NaN is present.
- R7: A compare result fills its lane with all ones when the predicate is true and with all zeros when it is false.
- R8: The ordering is exact on sign-magnitude values. +0 and -0 are equal, and when both inputs are negative the one with the larger magnitude is the smaller value. Infinities order beyond every finite value.
- R9: With `scalar_only`=1, only the lowest lane carries the computed value. All higher bits of the result equal the matching bits of `src_a`.
- R10: With `OUT_REG`=1 (the default), `result` reflects the inputs sampled at the previous rising clock edge. When `rst_n` is low at an edge, `result` becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 128 | First operand; also supplies preserved bits in scalar mode |
| src_b | input | 128 | Second operand |
| func_sel | input | 2 | Function: compare, minimum, maximum |
| pred_sel | input | 3 | Compare predicate code |
| wide_lane | input | 1 | 0 = 32-bit lanes, 1 = 64-bit lanes |
| scalar_only | input | 1 | 1 = only the lowest lane is computed |
| result | output | 128 | Per-lane result |

## Verification
The cases that are hard to reach from the ports are the ties and unordered pairs: +0 against -0, equal negatives, a quiet NaN against a signalling NaN in either position. Each of them must reach every lane in both widths while the other lanes hold unrelated pairs. The bench uses a fixed table of ten encodings per width: both zeros, both infinities, positive and negative normals, and both NaN kinds. Every ordered pair from the table goes to lane 0, and the other lanes receive rotated pairs, so each pair visits each lane. Each vector is repeated in packed and scalar mode under every predicate and both min and max. Expected results come from a rank number attached to each table entry, not from the bit patterns.

// File: rtl/pfcmp_pkg.sv
// Package: shared encodings and lane geometry for the packed compare unit.
// Assumes IEEE-754 binary32 and binary64 layouts.
package pfcmp_pkg;

    // Function select codes (code 3 falls back to compare).
    typedef enum logic [1:0] {
        FN_CMP = 2'd0,
        FN_MIN = 2'd1,
        FN_MAX = 2'd2,
        FN_RSV = 2'd3
    } fn_e;

    // Compare predicate codes.
    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NEQ   = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } pred_e;

    localparam int NARROW_W     = 32;
    localparam int NARROW_EXP_W = 8;
    localparam int WIDE_W       = 64;
    localparam int WIDE_EXP_W   = 11;

endpackage

// File: rtl/pfcmp_classify.sv
// Module: pfcmp_classify
// Classifies one pair of floating-point lane values. It reports NaN flags and
// exact equality and less-than in both directions on sign-magnitude values.
// Assumes W = 1 sign + EXP_W exponent + fraction. Outputs are purely combinational.
module pfcmp_classify #(
    parameter int W     = 32,
    parameter int EXP_W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         nan_a,
    output logic         nan_b,
    output logic         snan_b,
    output logic         is_eq,
    output logic         a_lt_b,
    output logic         b_lt_a
);
    localparam int FRAC_W = W - 1 - EXP_W;
    localparam int MAG_W  = W - 1;

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             both_zero, any_nan;
    logic             raw_ab, raw_ba;

    // Split each operand into sign and magnitude.
    always_comb begin
        sgn_a = op_a[W-1];
        sgn_b = op_b[W-1];
        mag_a = op_a[MAG_W-1:0];
        mag_b = op_b[MAG_W-1:0];
    end

    // NaN detection: all-ones exponent with a nonzero fraction.
    always_comb begin
        nan_a  = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
        nan_b  = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
        snan_b = nan_b && !op_b[FRAC_W-1];
        any_nan = nan_a || nan_b;
        both_zero = (mag_a == '0) && (mag_b == '0);
    end

    // Raw sign-magnitude ordering, ignoring NaN.
    always_comb begin
        if (both_zero) begin
            raw_ab = 1'b0;
            raw_ba = 1'b0;
        end else if (sgn_a != sgn_b) begin
            raw_ab = sgn_a;
            raw_ba = sgn_b;
        end else if (!sgn_a) begin
            raw_ab = mag_a < mag_b;
            raw_ba = mag_b < mag_a;
        end else begin
            raw_ab = mag_a > mag_b;
            raw_ba = mag_b > mag_a;
        end
    end

    // Final ordered relations: false whenever a NaN is present.
    always_comb begin
        is_eq  = !any_nan && ((op_a == op_b) || both_zero);
        a_lt_b = !any_nan && raw_ab;
        b_lt_a = !any_nan && raw_ba;
    end

    // R8: the three ordered relations are mutually exclusive.
    always_comb begin
        a_r8_order_exclusive: assert (!(a_lt_b && b_lt_a) && !(is_eq && (a_lt_b || b_lt_a)));
    end

    // R6: a NaN input never compares equal.
    always_comb begin
        if (nan_a || nan_b) begin
            a_r6_nan_not_equal: assert (!is_eq);
        end
    end

endmodule

// File: rtl/pfcmp_lane.sv
// Module: pfcmp_lane
// Computes one lane result: a full-width predicate mask, or the minimum or
// maximum with second-operand preference on ties and NaNs.
// Assumes func/pred codes from pfcmp_pkg. Purely combinational.
module pfcmp_lane
    import pfcmp_pkg::*;
#(
    parameter int W     = 32,
    parameter int EXP_W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   fn,
    input  logic [2:0]   pred,
    output logic [W-1:0] res
);
    logic nan_a, nan_b, snan_b, is_eq, a_lt_b, b_lt_a;
    logic pred_hit;
    logic any_nan;

    pfcmp_classify #(.W(W), .EXP_W(EXP_W)) u_cls (
        .op_a   (op_a),
        .op_b   (op_b),
        .nan_a  (nan_a),
        .nan_b  (nan_b),
        .snan_b (snan_b),
        .is_eq  (is_eq),
        .a_lt_b (a_lt_b),
        .b_lt_a (b_lt_a)
    );

    assign any_nan = nan_a || nan_b;

    // Evaluate the selected predicate; negated forms become true on NaN.
    always_comb begin
        case (pred_e'(pred))
            PR_EQ:    pred_hit = is_eq;
            PR_LT:    pred_hit = a_lt_b;
            PR_LE:    pred_hit = a_lt_b || is_eq;
            PR_UNORD: pred_hit = any_nan;
            PR_NEQ:   pred_hit = !is_eq;
            PR_NLT:   pred_hit = !a_lt_b;
            PR_NLE:   pred_hit = !(a_lt_b || is_eq);
            default:  pred_hit = !any_nan;
        endcase
    end

    // Select the lane result for the requested function.
    always_comb begin
        case (fn_e'(fn))
            FN_MIN:  res = (!any_nan && a_lt_b) ? op_a : op_b;
            FN_MAX:  res = (!any_nan && b_lt_a) ? op_a : op_b;
            default: res = {W{pred_hit}};
        endcase
    end

    // R7: compare output is a uniform lane mask.
    always_comb begin
        if (fn != 2'd1 && fn != 2'd2) begin
            a_r7_full_mask: assert (res == '0 || res == '1);
        end
    end

    // R5: a signalling NaN in the second operand is passed through by min/max.
    always_comb begin
        if ((fn == 2'd1 || fn == 2'd2) && snan_b) begin
            a_r5_snan_passes_b: assert (res == op_b);
        end
    end

    // R3: min/max always returns one of the two inputs unchanged.
    always_comb begin
        if (fn == 2'd1 || fn == 2'd2) begin
            a_r3_pick_input: assert (res == op_a || res == op_b);
        end
    end

endmodule

// File: rtl/vec_fcmp_minmax.sv
// Module: vec_fcmp_minmax
// Packed floating-point compare and min/max over a DATA_W-bit register pair.
// The 32-bit and 64-bit lane arrays are both built, and the width select
// picks one of them. Scalar mode keeps src_a above the lowest lane.
// Assumes DATA_W is a multiple of 64. OUT_REG adds one register stage
// with a synchronous active-low reset.
module vec_fcmp_minmax
    import pfcmp_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [1:0]        func_sel,
    input  logic [2:0]        pred_sel,
    input  logic              wide_lane,
    input  logic              scalar_only,
    output logic [DATA_W-1:0] result
);
    localparam int N_NARROW = DATA_W / NARROW_W;
    localparam int N_WIDE   = DATA_W / WIDE_W;

    logic [DATA_W-1:0] narrow_res;
    logic [DATA_W-1:0] wide_res;
    logic [DATA_W-1:0] merged;

    // Array of 32-bit lanes.
    for (genvar gi = 0; gi < N_NARROW; gi++) begin : g_narrow
        pfcmp_lane #(.W(NARROW_W), .EXP_W(NARROW_EXP_W)) u_lane (
            .op_a (src_a[gi*NARROW_W +: NARROW_W]),
            .op_b (src_b[gi*NARROW_W +: NARROW_W]),
            .fn   (func_sel),
            .pred (pred_sel),
            .res  (narrow_res[gi*NARROW_W +: NARROW_W])
        );
    end

    // Array of 64-bit lanes.
    for (genvar gj = 0; gj < N_WIDE; gj++) begin : g_wide
        pfcmp_lane #(.W(WIDE_W), .EXP_W(WIDE_EXP_W)) u_lane (
            .op_a (src_a[gj*WIDE_W +: WIDE_W]),
            .op_b (src_b[gj*WIDE_W +: WIDE_W]),
            .fn   (func_sel),
            .pred (pred_sel),
            .res  (wide_res[gj*WIDE_W +: WIDE_W])
        );
    end

    // Choose the lane width, then in scalar mode restore src_a above lane 0.
    always_comb begin
        merged = wide_lane ? wide_res : narrow_res;
        if (scalar_only) begin
            if (wide_lane) begin
                merged[DATA_W-1:WIDE_W] = src_a[DATA_W-1:WIDE_W];
            end else begin
                merged[DATA_W-1:NARROW_W] = src_a[DATA_W-1:NARROW_W];
            end
        end
    end

    if (OUT_REG) begin : g_reg
        // Output stage: capture the merged result, or clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) result <= '0;
            else        result <= merged;
        end

        // R10: reset clears the output on the following edge.
        a_r10_reset_clears: assert property (@(posedge clk)
            !rst_n |=> result == '0);

        // R9: scalar 32-bit mode keeps src_a above the lowest lane.
        a_r9_scalar_keep_narrow: assert property (@(posedge clk) disable iff (!rst_n)
            (scalar_only && !wide_lane) |=>
                result[DATA_W-1:NARROW_W] == $past(src_a[DATA_W-1:NARROW_W]));

        // R9: scalar 64-bit mode keeps src_a above the lowest lane.
        a_r9_scalar_keep_wide: assert property (@(posedge clk) disable iff (!rst_n)
            (scalar_only && wide_lane) |=>
                result[DATA_W-1:WIDE_W] == $past(src_a[DATA_W-1:WIDE_W]));
    end else begin : g_comb
        assign result = merged;
    end

endmodule

// File: tb/vec_fcmp_minmax_test.sv
module vec_fcmp_minmax_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_a = '0, src_b = '0;
    logic [1:0]   func_sel = '0;
    logic [2:0]   pred_sel = '0;
    logic         wide_lane = 1'b0, scalar_only = 1'b0;
    logic [127:0] result;
    int checks = 0;
    int errors = 0;

    vec_fcmp_minmax uut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .func_sel(func_sel), .pred_sel(pred_sel), .wide_lane(wide_lane),
        .scalar_only(scalar_only), .result(result)
    );

    always #2 clk = ~clk;

    // Table: 0 -inf, 1 -2, 2 -1, 3 -0, 4 +0, 5 1, 6 1.5, 7 +inf, 8 qNaN, 9 sNaN
    function automatic logic [31:0] v32(int i);
        case (i)
            0: return 32'hFF80_0000; 1: return 32'hC000_0000;
            2: return 32'hBF80_0000; 3: return 32'h8000_0000;
            4: return 32'h0000_0000; 5: return 32'h3F80_0000;
            6: return 32'h3FC0_0000; 7: return 32'h7F80_0000;
            8: return 32'h7FC0_0001; default: return 32'h7F80_0001;
        endcase
    endfunction

    function automatic logic [63:0] v64(int i);
        case (i)
            0: return 64'hFFF0_0000_0000_0000; 1: return 64'hC000_0000_0000_0000;
            2: return 64'hBFF0_0000_0000_0000; 3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_0000_0000; 5: return 64'h3FF0_0000_0000_0000;
            6: return 64'h3FF8_0000_0000_0000; 7: return 64'h7FF0_0000_0000_0000;
            8: return 64'h7FF8_0000_0000_0001; default: return 64'h7FF0_0000_0000_0001;
        endcase
    endfunction

    function automatic real rk(int i);
        case (i)
            0: return -100.0; 1: return -2.0; 2: return -1.0;
            3: return 0.0; 4: return 0.0; 5: return 1.0;
            6: return 1.5; 7: return 100.0; default: return 0.0;
        endcase
    endfunction

    function automatic bit isn(int i);
        return i >= 8;
    endfunction

    function automatic bit pred_truth(int p, int i, int j);
        bit n = isn(i) || isn(j);
        case (p)
            0: return !n && rk(i) == rk(j);
            1: return !n && rk(i) < rk(j);
            2: return !n && rk(i) <= rk(j);
            3: return n;
            4: return n || rk(i) != rk(j);
            5: return n || !(rk(i) < rk(j));
            6: return n || !(rk(i) <= rk(j));
            default: return !n;
        endcase
    endfunction

    task automatic run_vec(int fn, int p, bit wide, bit scal, int i0, int j0);
        int ia[4], ja[4];
        int nl = wide ? 2 : 4;
        logic [63:0] got, exp_v, av, bv;
        bit n, t;
        string tag;
        for (int k = 0; k < 4; k++) begin
            ia[k] = (i0 + k) % 10;
            ja[k] = (j0 + 3 * k) % 10;
        end
        for (int k = 0; k < 4; k++) begin
            if (wide) begin
                if (k < 2) begin
                    src_a[k*64 +: 64] = v64(ia[k]);
                    src_b[k*64 +: 64] = v64(ja[k]);
                end
            end else begin
                src_a[k*32 +: 32] = v32(ia[k]);
                src_b[k*32 +: 32] = v32(ja[k]);
            end
        end
        func_sel = fn[1:0]; pred_sel = p[2:0]; wide_lane = wide; scalar_only = scal;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < nl; k++) begin
            av = wide ? v64(ia[k]) : {32'b0, v32(ia[k])};
            bv = wide ? v64(ja[k]) : {32'b0, v32(ja[k])};
            got = wide ? result[k*64 +: 64] : {32'b0, result[k*32 +: 32]};
            n = isn(ia[k]) || isn(ja[k]);
            if (scal && k > 0) begin
                exp_v = av; tag = "R9";
            end else if (fn == 1) begin
                exp_v = (!n && rk(ia[k]) < rk(ja[k])) ? av : bv;
                tag = n ? "R5" : "R3";
            end else if (fn == 2) begin
                exp_v = (!n && rk(ja[k]) < rk(ia[k])) ? av : bv;
                tag = n ? "R5" : "R4";
            end else begin
                t = pred_truth(p, ia[k], ja[k]);
                exp_v = t ? (wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF) : 64'h0;
                if (fn == 3) tag = "R2";
                else if (n) tag = "R6";
                else if (rk(ia[k]) <= 0.0 && rk(ja[k]) <= 0.0) tag = "R8";
                else tag = "R7";
            end
            if (wide && k == 1 && !scal && tag != "R5") tag = "R1";
            checks++;
            if (got !== exp_v) begin
                errors++;
                $display("FAIL %s fn=%0d pred=%0d wide=%0d scalar=%0d lane=%0d a=%h b=%h actual=%h expected=%h",
                         tag, fn, p, wide, scal, k, av, bv, got, exp_v);
            end
        end
    endtask

    initial begin : watchdog
        #(4ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        // R10: result held at zero while reset is asserted with busy inputs.
        src_a = {4{32'h3F80_0000}};
        src_b = {4{32'hBF80_0000}};
        func_sel = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== '0) begin
            errors++;
            $display("FAIL R10 reset actual=%h expected=%h", result, 128'h0);
        end
        rst_n = 1'b1;
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 10; i++) begin
                    for (int j = 0; j < 10; j++) begin
                        for (int p = 0; p < 8; p++) run_vec(0, p, w[0], s[0], i, j);
                        run_vec(1, 0, w[0], s[0], i, j);
                        run_vec(2, 0, w[0], s[0], i, j);
                        run_vec(3, (i + j) % 8, w[0], s[0], i, j);
                    end
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule